// File: doc/BRIEF.md
# Multichannel ADC Threshold Alarm Unit

This block keeps a pair of 8-bit alarm limits, one low and one high, for each channel of a multichannel analog-to-digital converter. The limits live in a small byte-addressed register page that a host reaches through a simple write strobe and a registered read port. Each time a channel delivers a fresh conversion result, the block compares that result against the channel's two limits and raises a sticky low or high alarm flag.

Conversion results arrive left-justified in a 16-bit word together with a per-channel resolution code. The limits are always eight bits. At eight bits of resolution or more, the comparison uses the top byte of the result. Below eight bits, only the top N bits of the result and of each limit take part, and the unused limit bits are masked out. Flags stay set until a per-channel clear or reset.

Top module: `adc_alarm_unit`

## Requirements
- R1: The limit page covers byte addresses 0x10 to 0x17. Channel k (0 to 3) keeps its low limit at 0x10+2k and its high limit at 0x11+2k. A cycle with `cfg_wr` high and an in-page `cfg_addr` stores `cfg_wdata` into that byte.
- R2: After reset, every low limit reads 0x00, every high limit reads 0xFF, every alarm flag is 0 and `cfg_rdata` is 0x00.
- R3: A cycle with `cfg_rd` high places the addressed byte on `cfg_rdata` after the next clock edge. That byte is the value held before any write in the same cycle. A read of an address outside the page returns 0x00.
- R4: Writes to addresses outside 0x10 to 0x17 change no limit.
- R5: When a result is valid and the resolution is 8 bits or more, the channel's high flag is set if bits [15:8] of the result are greater than the high limit.
- R6: Under the same condition, the channel's low flag is set if bits [15:8] of the result are less than the low limit.
- R7: The resolution code is 4 bits wide. Code 0 means 16 bits, and codes 1 to 15 mean that many bits. For a resolution N below 8, both comparisons use the top N bits of result bits [15:8] against the top N bits of each limit, and the low 8-N bits play no part.
- R8: A flag is set at the clock edge that samples a valid matching result, with the comparison made against the limits held before that edge. Once set, it stays set through later non-matching results.
- R9: A high `alarm_clr[k]` clears both flags of channel k at the next edge. If a matching valid result arrives in the same cycle, the new setting wins.
- R10: Channels are independent. Results, clears and limits of one channel never change another channel's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Limit page write strobe |
| cfg_rd | input | 1 | Limit page read strobe |
| cfg_addr | input | 8 | Byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| conv_valid | input | 4 | Per-channel new-result strobe |
| conv_data | input | 64 | Per-channel left-justified 16-bit results, channel k at [16k+15:16k] |
| conv_res | input | 16 | Per-channel 4-bit resolution codes, channel k at [4k+3:4k] |
| alarm_clr | input | 4 | Per-channel flag clear |
| alarm_lo | output | 4 | Sticky below-low flags |
| alarm_hi | output | 4 | Sticky above-high flags |

## Verification
The check that a channel never flags low and high together assumes the low limit is no greater than the high limit. For that reason it is guarded by that ordering and does not act on inverted limits, which the random stimulus also writes now and then. The register-port properties assume the address is held steady during a strobe cycle. The bench changes every input only at the falling edge. Random results use all 4-bit resolution codes, including the 0 code for 16 bits. Random writes span a window a few bytes wider than the page, so the off-page paths are exercised under the same rules.

// File: rtl/adc_alarm_pkg.sv
package adc_alarm_pkg;
    localparam int LIMIT_W = 8;
    localparam int CODE_W  = 4;
    localparam int WORD_W  = 16;

    typedef logic [LIMIT_W-1:0] limit_t;

    // Mask for the significant bits of the top byte for a resolution code.
    // Code 0 stands for full 16-bit resolution.
    function automatic limit_t sig_mask(input logic [CODE_W-1:0] code);
        int n;
        n = (code == '0) ? WORD_W : int'(code);
        if (n >= LIMIT_W)
            return '1;
        return limit_t'(8'hFF << (LIMIT_W - n));
    endfunction
endpackage

// File: rtl/adc_alarm_regs.sv
module adc_alarm_regs
    import adc_alarm_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int PAGE_BASE = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  limit_t                    wdata,
    output limit_t                    rdata,
    output logic [NUM_CH*LIMIT_W-1:0] lo_flat,
    output logic [NUM_CH*LIMIT_W-1:0] hi_flat
);
    localparam int PAGE_BYTES = 2 * NUM_CH;
    localparam int SLOT_W     = ADDR_W - 1;

    typedef struct packed {
        logic [NUM_CH-1:0][LIMIT_W-1:0] lo;
        logic [NUM_CH-1:0][LIMIT_W-1:0] hi;
        limit_t                         rd;
    } page_t;

    page_t state_d, state_q;

    logic [ADDR_W-1:0] offset;
    logic              in_page;
    logic [SLOT_W-1:0] slot;
    logic              hi_half;

    assign offset  = addr - ADDR_W'(PAGE_BASE);
    assign in_page = (addr >= ADDR_W'(PAGE_BASE)) &&
                     (offset < ADDR_W'(PAGE_BYTES));
    assign slot    = offset[ADDR_W-1:1];
    assign hi_half = offset[0];

    always_comb begin
        state_d = state_q;
        if (rd_en) begin
            state_d.rd = '0;
            for (int k = 0; k < NUM_CH; k++) begin
                if (in_page && slot == SLOT_W'(k))
                    state_d.rd = hi_half ? state_q.hi[k] : state_q.lo[k];
            end
        end
        if (wr_en && in_page) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (slot == SLOT_W'(k)) begin
                    if (hi_half)
                        state_d.hi[k] = wdata;
                    else
                        state_d.lo[k] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.lo <= '0;
            state_q.hi <= '1;
            state_q.rd <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata   = state_q.rd;
    assign lo_flat = state_q.lo;
    assign hi_flat = state_q.hi;

    // Writes outside the page leave every limit untouched.
    assert_offpage_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_page) |=> ($stable(state_q.lo) && $stable(state_q.hi)));

    // An in-page write to the first low slot lands there.
    assert_write_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(PAGE_BASE)) |=> (state_q.lo[0] == $past(wdata)));

    // Reads outside the page return zero.
    assert_rd_offpage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_page) |=> (rdata == '0));
endmodule

// File: rtl/adc_alarm_cmp.sv
module adc_alarm_cmp
    import adc_alarm_pkg::*;
(
    input  logic [WORD_W-1:0] result,
    input  logic [CODE_W-1:0] code,
    input  limit_t            lim_lo,
    input  limit_t            lim_hi,
    output logic              below,
    output logic              above
);
    limit_t mask;
    limit_t top_m;
    limit_t lo_m;
    limit_t hi_m;

    always_comb begin
        mask  = sig_mask(code);
        top_m = result[WORD_W-1 -: LIMIT_W] & mask;
        lo_m  = lim_lo & mask;
        hi_m  = lim_hi & mask;
        below = top_m < lo_m;
        above = top_m > hi_m;
    end

    // With ordered limits a sample cannot lie on both sides.
    always_comb begin
        if (lim_lo <= lim_hi)
            assert_no_dual_R7: assert (!(below && above));
    end
endmodule

// File: rtl/adc_alarm_flags.sv
module adc_alarm_flags #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] valid,
    input  logic [NUM_CH-1:0] clr,
    input  logic [NUM_CH-1:0] below,
    input  logic [NUM_CH-1:0] above,
    output logic [NUM_CH-1:0] lo_flag,
    output logic [NUM_CH-1:0] hi_flag
);
    typedef struct packed {
        logic [NUM_CH-1:0] lo;
        logic [NUM_CH-1:0] hi;
    } flag_t;

    flag_t state_d, state_q;

    always_comb begin
        state_d.lo = (state_q.lo & ~clr) | (valid & below);
        state_d.hi = (state_q.hi & ~clr) | (valid & above);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign lo_flag = state_q.lo;
    assign hi_flag = state_q.hi;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        assert_sticky_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_flag[k] && !clr[k]) |=> hi_flag[k]);
        assert_sticky_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_flag[k] && !clr[k]) |=> lo_flag[k]);
        assert_clear_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !(valid[k] && below[k])) |=> !lo_flag[k]);
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && valid[k] && above[k]) |=> hi_flag[k]);
    end
endmodule

// File: rtl/adc_alarm_unit.sv
module adc_alarm_unit
    import adc_alarm_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int PAGE_BASE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic                     cfg_rd,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [LIMIT_W-1:0]       cfg_wdata,
    output logic [LIMIT_W-1:0]       cfg_rdata,
    input  logic [NUM_CH-1:0]        conv_valid,
    input  logic [NUM_CH*WORD_W-1:0] conv_data,
    input  logic [NUM_CH*CODE_W-1:0] conv_res,
    input  logic [NUM_CH-1:0]        alarm_clr,
    output logic [NUM_CH-1:0]        alarm_lo,
    output logic [NUM_CH-1:0]        alarm_hi
);
    logic [NUM_CH*LIMIT_W-1:0] lo_flat;
    logic [NUM_CH*LIMIT_W-1:0] hi_flat;
    logic [NUM_CH-1:0]         below;
    logic [NUM_CH-1:0]         above;

    adc_alarm_regs #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .PAGE_BASE(PAGE_BASE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .rd_en  (cfg_rd),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .lo_flat(lo_flat),
        .hi_flat(hi_flat)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        adc_alarm_cmp u_cmp (
            .result(conv_data[k*WORD_W +: WORD_W]),
            .code  (conv_res[k*CODE_W +: CODE_W]),
            .lim_lo(lo_flat[k*LIMIT_W +: LIMIT_W]),
            .lim_hi(hi_flat[k*LIMIT_W +: LIMIT_W]),
            .below (below[k]),
            .above (above[k])
        );
    end

    adc_alarm_flags #(
        .NUM_CH(NUM_CH)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (conv_valid),
        .clr    (alarm_clr),
        .below  (below),
        .above  (above),
        .lo_flag(alarm_lo),
        .hi_flag(alarm_hi)
    );
endmodule

// File: tb/adc_alarm_unit_test.sv
module adc_alarm_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [7:0]  cfg_addr = 0, cfg_wdata = 0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  conv_valid = 0, alarm_clr = 0;
    logic [63:0] conv_data = 0;
    logic [15:0] conv_res = 0;
    logic [3:0]  alarm_lo, alarm_hi;

    int errors = 0, checks = 0;
    logic [7:0] m_lo[4];
    logic [7:0] m_hi[4];
    logic [3:0] m_flo = 0, m_fhi = 0;
    logic [7:0] m_rd = 0;

    always #10 clk = ~clk;

    adc_alarm_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .conv_valid(conv_valid), .conv_data(conv_data), .conv_res(conv_res),
        .alarm_clr(alarm_clr), .alarm_lo(alarm_lo), .alarm_hi(alarm_hi)
    );

    function automatic logic [7:0] exp_mask(input logic [3:0] code);
        int n = (code == 0) ? 16 : int'(code);
        if (n >= 8) return 8'hFF;
        return 8'((8'hFF << (8 - n)));
    endfunction

    function automatic logic exp_above(input logic [15:0] d, input logic [3:0] c, input logic [7:0] th);
        return (d[15:8] & exp_mask(c)) > (th & exp_mask(c));
    endfunction

    function automatic logic exp_below(input logic [15:0] d, input logic [3:0] c, input logic [7:0] th);
        return (d[15:8] & exp_mask(c)) < (th & exp_mask(c));
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock cycle with the inputs currently driven; model mirrors it.
    task automatic step(input string tag);
        logic [7:0] off;
        logic in_pg;
        off   = cfg_addr - 8'h10;
        in_pg = cfg_addr >= 8'h10 && cfg_addr <= 8'h17;
        if (cfg_rd) m_rd = in_pg ? (off[0] ? m_hi[off[3:1]] : m_lo[off[3:1]]) : 8'h00;
        for (int k = 0; k < 4; k++) begin
            logic b, a;
            b = conv_valid[k] && exp_below(conv_data[16*k +: 16], conv_res[4*k +: 4], m_lo[k]);
            a = conv_valid[k] && exp_above(conv_data[16*k +: 16], conv_res[4*k +: 4], m_hi[k]);
            m_flo[k] = (m_flo[k] && !alarm_clr[k]) || b;
            m_fhi[k] = (m_fhi[k] && !alarm_clr[k]) || a;
        end
        if (cfg_wr && in_pg) begin
            if (off[0]) m_hi[off[3:1]] = cfg_wdata;
            else        m_lo[off[3:1]] = cfg_wdata;
        end
        @(negedge clk);
        check(alarm_lo == m_flo, {tag, " low flags"}, alarm_lo, m_flo);
        check(alarm_hi == m_fhi, {tag, " high flags"}, alarm_hi, m_fhi);
        check(cfg_rdata == m_rd, {tag, " read data"}, cfg_rdata, m_rd);
        cfg_wr = 0; cfg_rd = 0; conv_valid = 0; alarm_clr = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d; step(tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cfg_rd = 1; cfg_addr = a; step(tag);
    endtask

    task automatic conv(input int k, input logic [15:0] d, input logic [3:0] c, input string tag);
        conv_valid[k] = 1; conv_data[16*k +: 16] = d; conv_res[4*k +: 4] = c; step(tag);
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed = 2024;
        void'($urandom(seed));
        for (int k = 0; k < 4; k++) begin m_lo[k] = 8'h00; m_hi[k] = 8'hFF; end
        repeat (3) @(negedge clk);
        check(alarm_lo == 0 && alarm_hi == 0, "R2 flags at reset", {alarm_lo, alarm_hi}, 0);
        check(cfg_rdata == 0, "R2 read data at reset", cfg_rdata, 0);
        rst_n = 1;
        @(negedge clk);
        for (int a = 8'h10; a <= 8'h17; a++) rd(8'(a), "R2 default limit");

        // R1: per-channel addressing
        wr(8'h10, 8'h40, "R1 write A low");
        wr(8'h11, 8'hC0, "R1 write A high");
        wr(8'h16, 8'h21, "R1 write D low");
        rd(8'h16, "R1 readback D low");
        rd(8'h11, "R1 readback A high");

        // R5 / R8 / R9
        conv(0, 16'hD000, 4'd0, "R5 above high at 16 bits");
        conv(0, 16'h8000, 4'd8, "R8 flag sticks");
        alarm_clr[0] = 1; step("R9 clear");
        alarm_clr[0] = 1; conv(0, 16'hC100, 4'd8, "R9 set wins over clear");
        alarm_clr[0] = 1; step("R9 clear again");
        // R6
        conv(0, 16'h3F00, 4'd12, "R6 below low");
        alarm_clr[0] = 1; step("R6 clear");
        // R7: 3-bit resolution masks the low five bits
        conv(0, 16'hDF00, 4'd3, "R7 no high at 3 bits");
        conv(0, 16'h5F00, 4'd1, "R7 no low at 1 bit");
        conv(0, 16'h2000, 4'd2, "R7 low at 2 bits");
        // R10: other channel untouched
        conv(3, 16'h0000, 4'd8, "R10 channel D below");
        // R4 / R3 off-page
        wr(8'h18, 8'h55, "R4 off-page write");
        wr(8'h0F, 8'h55, "R4 off-page write low side");
        rd(8'h18, "R3 off-page read zero");
        for (int a = 8'h10; a <= 8'h17; a++) rd(8'(a), "R4 page unchanged");
        // R3: read and write same cycle returns old byte
        cfg_rd = 1; wr(8'h12, 8'h77, "R3 read before write");
        rd(8'h12, "R3 read after write");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                cfg_wr = 1; cfg_addr = 8'($urandom_range(8'h0C, 8'h1B));
                cfg_wdata = 8'($urandom);
            end
            if ($urandom_range(0, 2) == 0) begin
                cfg_rd = 1;
                if (!cfg_wr) cfg_addr = 8'($urandom_range(8'h0C, 8'h1B));
            end
            conv_valid = 4'($urandom);
            conv_data  = {$urandom, $urandom};
            conv_res   = 16'($urandom);
            alarm_clr  = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
            step("R10 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule